// File: doc/BRIEF.md
# Interrupt Vector Register

This block turns a set of pending-condition flags into a single read-only vector. The vector holds a 4-bit source code placed so that software can use the read value directly as an offset into a jump table. When several flags are pending, the highest-ranked one is reported. Fault-type events rank highest, then receive events, and transmit-empty ranks lowest. A code of zero means that nothing is pending.

The flags themselves are held outside the block. The block asks for a flag to be dropped by raising one bit of a clear-pulse output for a single cycle. Status-type sources clear as soon as a vector read reports them. Data-register sources need two steps. Receive-full and frame-reply-byte-received need a vector read and then a data-register read. Transmit-empty needs a vector read and then a data-register write, or it can be dropped directly by setting the end-of-data control bit.

Top module: `intr_vector_reg`

## Requirements
- R1: A read of the vector address returns the source code in bits 5:2 and zeros in bits 7, 6, 1 and 0. Flag bit i reports code i+1. The flag bits are: 0 transmit-empty, 1 receive-full, 2 reply-byte-received, 3 end-of-data seen, 4 end-of-frame seen, 5 break, 6 arbitration lost, 7 error.
- R2: After reset the vector reads zero, and a write to the vector address raises no clear pulse and leaves the reported code unchanged.
- R3: A vector read that reports a status source (flag bits 3 to 7) raises the clear pulse for that source alone, in the same cycle as the read.
- R4: A vector read that reports receive-full or reply-byte-received raises no clear pulse. A data-register read that follows it clears that source.
- R5: A vector read that reports transmit-empty raises no clear pulse. A following data-register write clears it, and a data-register read does not.
- R6: Asserting the end-of-data input clears transmit-empty in the same cycle, with no vector read needed.
- R7: When several flags are pending, the vector reports the highest flag index among them. With no flag pending it reports code 0.
- R8: A data-register access clears nothing unless the most recent vector read reported a data-register source. The first data-register access after that vector read consumes the permission.
- R9: A vector read clears only the source it reports. An event that arrives in the same cycle is kept and is reported later.
- R10: One cycle after a clear pulse, the vector reports the next pending source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_i | input | 8 | Pending-condition flags, held externally |
| rd_en_i | input | 1 | Bus read strobe |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | 3 | Register select |
| eod_set_i | input | 1 | Pulse when the end-of-data control bit is set |
| rd_data_o | output | 8 | Read value of the vector register, zero otherwise |
| clr_o | output | 8 | One-cycle clear request per flag |

## Verification
Two things can land in the same cycle: a vector read that clears the reported status source, and a new higher-ranked event arriving. The bench raises the error flag in exactly the cycle of a vector read that reports end-of-data-seen. It then checks three things: that the read returned the older code, that the clear pulse named only the older source, and that the error code appears on the following read. A second overlap happens when end-of-data is set while a vector read is in progress; the transmit-empty path covers this.

// File: rtl/ivr_pkg.sv
// Package: shared constants and the decoded bus-access type for the
// interrupt vector register. Assumes one bus access per cycle.
package ivr_pkg;

    localparam int CODE_W   = 4;   // width of the reported source code
    localparam int READ_W   = 8;   // width of the read value
    localparam int CODE_LSB = 2;   // position of the code's low bit

    // Flag positions; a higher index ranks higher.
    localparam int SRC_TX_EMPTY = 0;
    localparam int SRC_RX_FULL  = 1;
    localparam int SRC_REPLY_RX = 2;
    localparam int SRC_EOD_SEEN = 3;
    localparam int SRC_EOF_SEEN = 4;
    localparam int SRC_BREAK    = 5;
    localparam int SRC_ARB_LOST = 6;
    localparam int SRC_ERROR    = 7;

    // Decoded strobes for one bus cycle.
    typedef struct packed {
        logic vec_rd;
        logic vec_wr;
        logic dat_rd;
        logic dat_wr;
    } ivr_acc_t;

endpackage

// File: rtl/ivr_bus_dec.sv
// Bus decoder: turns read/write strobes and the register select into
// per-register access strobes. Assumes read and write are not both set.
module ivr_bus_dec
    import ivr_pkg::*;
#(
    parameter int             ADDR_W    = 3,
    parameter logic [ADDR_W-1:0] VEC_ADDR  = 3'd6,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 3'd7
) (
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output ivr_acc_t          acc_o
);

    logic hit_vec;
    logic hit_dat;

    // Compare the select against both register addresses.
    always_comb begin
        hit_vec = (addr_i == VEC_ADDR);
        hit_dat = (addr_i == DATA_ADDR);
    end

    // Combine address hits with the strobes.
    always_comb begin
        acc_o.vec_rd = rd_en_i & hit_vec;
        acc_o.vec_wr = wr_en_i & hit_vec;
        acc_o.dat_rd = rd_en_i & hit_dat;
        acc_o.dat_wr = wr_en_i & hit_dat;
    end

endmodule

// File: rtl/ivr_prio_enc.sv
// Priority encoder: reports code i+1 for the highest set request bit i,
// or zero when no bit is set. Assumes NSRC < 2**CODE_W.
module ivr_prio_enc #(
    parameter int NSRC   = 8,
    parameter int CODE_W = 4
) (
    input  logic [NSRC-1:0]   req_i,
    output logic [CODE_W-1:0] code_o
);

    // Scan upward so the highest set index is the last one written.
    always_comb begin
        code_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req_i[i]) code_o = CODE_W'(i + 1);
        end
    end

endmodule

// File: rtl/ivr_clear_ctl.sv
// Clear controller: raises the clear pulses for status sources on a
// vector read, arms data-register sources on a vector read, and fires
// their clear on the matching data access or on end-of-data.
// Assumes vec_code_i is the code shown by the current read.
module ivr_clear_ctl
    import ivr_pkg::*;
#(
    parameter int              NSRC    = 8,
    parameter int              CODE_W  = 4,
    parameter logic [NSRC-1:0] RD_MASK = 8'b0000_0110,
    parameter logic [NSRC-1:0] WR_MASK = 8'b0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ivr_acc_t          acc_i,
    input  logic              eod_set_i,
    input  logic [NSRC-1:0]   cond_i,
    input  logic [CODE_W-1:0] vec_code_i,
    output logic [NSRC-1:0]   clr_o
);

    localparam logic [NSRC-1:0] DATA_MASK = RD_MASK | WR_MASK;

    logic [NSRC-1:0] rep_oh;
    logic [NSRC-1:0] arm_q;
    logic [NSRC-1:0] arm_d;
    logic [NSRC-1:0] stat_clr;
    logic [NSRC-1:0] dat_clr;
    logic [NSRC-1:0] eod_clr;

    // Decode the reported code into a one-hot source mask.
    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_oh
            assign rep_oh[g] = (vec_code_i == CODE_W'(g + 1));
        end
    endgenerate

    // Build the three clear contributions and gate them with the flags.
    always_comb begin
        stat_clr = acc_i.vec_rd ? (rep_oh & ~DATA_MASK) : '0;
        dat_clr  = (acc_i.dat_rd ? (arm_q & RD_MASK) : '0)
                 | (acc_i.dat_wr ? (arm_q & WR_MASK) : '0);
        eod_clr  = eod_set_i ? WR_MASK : '0;
        clr_o    = (stat_clr | dat_clr | eod_clr) & cond_i;
    end

    // Next arm state: set by a vector read, consumed by a data access.
    always_comb begin
        if (acc_i.vec_rd)
            arm_d = rep_oh & DATA_MASK;
        else if (acc_i.dat_rd || acc_i.dat_wr)
            arm_d = '0;
        else
            arm_d = arm_q;
        if (eod_set_i) arm_d = arm_d & ~WR_MASK;
    end

    // Arm register.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= '0;
        else        arm_q <= arm_d;
    end

    AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i.dat_rd || acc_i.dat_wr) |=> (arm_q == '0)); // R8
    AST_SINGLE_STATUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i.vec_rd && !eod_set_i) |-> $onehot0(clr_o)); // R3
    AST_VEC_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i.vec_wr && !eod_set_i) |-> (clr_o == '0)); // R2
    AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i.dat_rd && (arm_q == '0) && !eod_set_i) |-> (clr_o == '0)); // R8

endmodule

// File: rtl/intr_vector_reg.sv
// Interrupt vector register top: holds the registered code of the
// highest pending flag, presents it on vector reads, and drives the
// flag clear pulses. Assumes flags drop the cycle after their pulse.
module intr_vector_reg
    import ivr_pkg::*;
#(
    parameter int                NSRC      = 8,
    parameter int                ADDR_W    = 3,
    parameter logic [ADDR_W-1:0] VEC_ADDR  = 3'd6,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 3'd7,
    parameter logic [NSRC-1:0]   RD_MASK   = 8'b0000_0110,
    parameter logic [NSRC-1:0]   WR_MASK   = 8'b0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   cond_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              eod_set_i,
    output logic [READ_W-1:0] rd_data_o,
    output logic [NSRC-1:0]   clr_o
);

    localparam int PAD_HI = READ_W - CODE_LSB - CODE_W;

    ivr_acc_t          acc;
    logic [CODE_W-1:0] vec_q;
    logic [CODE_W-1:0] vec_d;
    logic [NSRC-1:0]   remain;

    ivr_bus_dec #(
        .ADDR_W    (ADDR_W),
        .VEC_ADDR  (VEC_ADDR),
        .DATA_ADDR (DATA_ADDR)
    ) u_dec (
        .rd_en_i (rd_en_i),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .acc_o   (acc)
    );

    ivr_clear_ctl #(
        .NSRC    (NSRC),
        .CODE_W  (CODE_W),
        .RD_MASK (RD_MASK),
        .WR_MASK (WR_MASK)
    ) u_clr (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_i      (acc),
        .eod_set_i  (eod_set_i),
        .cond_i     (cond_i),
        .vec_code_i (vec_q),
        .clr_o      (clr_o)
    );

    // Flags still pending once this cycle's clears take effect.
    always_comb remain = cond_i & ~clr_o;

    ivr_prio_enc #(
        .NSRC   (NSRC),
        .CODE_W (CODE_W)
    ) u_enc (
        .req_i  (remain),
        .code_o (vec_d)
    );

    // Capture the code of the highest remaining flag every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) vec_q <= '0;
        else        vec_q <= vec_d;
    end

    // Present the padded code on a vector read only.
    always_comb begin
        rd_data_o = acc.vec_rd ? {{PAD_HI{1'b0}}, vec_q, {CODE_LSB{1'b0}}}
                               : '0;
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cond_i) == '0) |-> (vec_q == '0)); // R7
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_q <= CODE_W'(NSRC))); // R1
    AST_CLEARED_NOT_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_o != '0 && cond_i == clr_o) |=> (vec_q == '0)); // R10

endmodule

// File: tb/intr_vector_reg_tb.sv
module intr_vector_reg_tb;

    localparam logic [2:0] A_VEC = 3'd6;
    localparam logic [2:0] A_DAT = 3'd7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] flags;
    logic [7:0] evt = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic       eod = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] clr;
    int         total = 0;
    int         bad = 0;
    logic       done = 1'b0;

    always #10 clk = ~clk;

    intr_vector_reg u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_i    (flags),
        .rd_en_i   (rd_en),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .eod_set_i (eod),
        .rd_data_o (rd_data),
        .clr_o     (clr)
    );

    // Environment model of the externally held flags.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags | evt) & ~clr;
    end

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One bus cycle starting at a negedge; samples outputs mid-cycle.
    task automatic bus(input logic rd, input logic wr, input logic [2:0] a,
                       input logic e, input logic [7:0] ev,
                       output logic [7:0] rdat, output logic [7:0] cl);
        rd_en = rd; wr_en = wr; addr = a; eod = e; evt = ev;
        #1;
        rdat = rd_data; cl = clr;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; eod = 1'b0; evt = '0;
    endtask

    // Raise events; the new code is visible when this returns.
    task automatic post(input logic [7:0] m);
        evt = m;
        @(negedge clk);
        evt = '0;
        @(negedge clk);
    endtask

    function automatic logic [7:0] vv(input int code);
        return 8'(code << 2);
    endfunction

    task automatic t_reset();
        logic [7:0] d, c;
        bus(1, 0, A_VEC, 0, 0, d, c);
        check("R2", "reset vector", d, 8'h00);
        check("R2", "reset clear", c, 8'h00);
    endtask

    task automatic t_status();
        logic [7:0] d, c;
        post(8'h40);
        bus(1, 0, A_VEC, 0, 0, d, c);
        check("R1", "arb code layout", d, vv(7));
        check("R3", "arb clear pulse", c, 8'h40);
        bus(1, 0, A_VEC, 0, 0, d, c);
        check("R3", "after status clear", d, 8'h00);
    endtask

    task automatic t_priority();
        logic [7:0] d, c;
        post(8'h98);
        bus(1, 0, A_VEC, 0, 0, d, c);
        check("R7", "highest is error", d, vv(8));
        check("R3", "error pulse", c, 8'h80);
        bus(1, 0, A_VEC, 0, 0, d, c);
        check("R10", "next is eof", d, vv(5));
        bus(1, 0, A_VEC, 0, 0, d, c);
        check("R10", "next is eod", d, vv(4));
        bus(1, 0, A_VEC, 0, 0, d, c);
        check("R7", "none left", d, 8'h00);
    endtask

    task automatic t_rx();
        logic [7:0] d, c;
        post(8'h02);
        bus(1, 0, A_VEC, 0, 0, d, c);
        check("R4", "rx full code", d, vv(2));
        check("R4", "no pulse on vec read", c, 8'h00);
        bus(1, 0, A_VEC, 0, 0, d, c);
        check("R4", "still rx full", d, vv(2));
        bus(1, 0, A_DAT, 0, 0, d, c);
        check("R4", "data read clears", c, 8'h02);
        bus(1, 0, A_VEC, 0, 0, d, c);
        check("R4", "rx full gone", d, 8'h00);
    endtask

    task automatic t_unarmed();
        logic [7:0] d, c;
        post(8'h04);
        bus(1, 0, A_DAT, 0, 0, d, c);
        check("R8", "unarmed data read", c, 8'h00);
        bus(1, 0, A_VEC, 0, 0, d, c);
        check("R8", "reply still pending", d, vv(3));
        bus(1, 0, A_DAT, 0, 0, d, c);
        check("R4", "reply cleared", c, 8'h04);
        post(8'h02);
        bus(1, 0, A_DAT, 0, 0, d, c);
        check("R8", "permission consumed", c, 8'h00);
        bus(1, 0, A_VEC, 0, 0, d, c);
        check("R8", "rx full kept", d, vv(2));
        bus(1, 0, A_DAT, 0, 0, d, c);
        check("R4", "rx full cleared", c, 8'h02);
    endtask

    task automatic t_tx();
        logic [7:0] d, c;
        post(8'h01);
        bus(1, 0, A_VEC, 0, 0, d, c);
        check("R5", "tx empty code", d, vv(1));
        check("R5", "no pulse on vec read", c, 8'h00);
        bus(1, 0, A_DAT, 0, 0, d, c);
        check("R5", "data read does not clear tx", c, 8'h00);
        bus(1, 0, A_VEC, 0, 0, d, c);
        bus(0, 1, A_DAT, 0, 0, d, c);
        check("R5", "data write clears tx", c, 8'h01);
        bus(1, 0, A_VEC, 0, 0, d, c);
        check("R5", "tx gone", d, 8'h00);
    endtask

    task automatic t_eod();
        logic [7:0] d, c;
        post(8'h01);
        bus(0, 0, A_VEC, 1, 0, d, c);
        check("R6", "eod clears tx", c, 8'h01);
        bus(1, 0, A_VEC, 0, 0, d, c);
        check("R6", "tx gone after eod", d, 8'h00);
    endtask

    task automatic t_write();
        logic [7:0] d, c;
        post(8'h20);
        bus(0, 1, A_VEC, 0, 0, d, c);
        check("R2", "write no pulse", c, 8'h00);
        bus(1, 0, A_VEC, 0, 0, d, c);
        check("R2", "break still shown", d, vv(6));
    endtask

    task automatic t_overlap();
        logic [7:0] d, c;
        post(8'h08);
        bus(1, 0, A_VEC, 0, 8'h80, d, c);
        check("R9", "older code read", d, vv(4));
        check("R9", "only older cleared", c, 8'h08);
        @(negedge clk);
        bus(1, 0, A_VEC, 0, 0, d, c);
        check("R9", "new event reported", d, vv(8));
        check("R9", "new event cleared", c, 8'h80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status();
        t_priority();
        t_rx();
        t_unarmed();
        t_tx();
        t_eod();
        t_write();
        t_overlap();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule